// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Hardware Repeat

This block holds a core's program counter as a word address and produces the byte address used to fetch the next instruction word. Two 16-bit map registers route each fetch. One byte-address bit chooses which map applies. The chosen map then sends the fetch either to the internal instruction store or to one of 256 unified memory regions. If the chosen region is not populated, the block raises a fault, which the core treats as an illegal-instruction exception. A parameter mask lists which regions are populated.

Each step-enable pulse retires one instruction. The PC moves to a branch target when the instruction changed it, and otherwise moves forward by one word. A zero-overhead repeat loop, set up with start, end and count values, sends the PC back to the loop start each time the stepped PC reaches the loop end. It ends the loop when the count runs out. Decoding the fetched word is done elsewhere.

Top module: `pcseq_top`

## Requirements
- R1: `fetch_addr` always equals the current word PC shifted left by two bits, with the two low bits zero.
- R2: While `rst_n` is low at a clock edge, the PC loads `start_addr` shifted right by two, both maps load 0x1000, and repeat becomes inactive.
- R3: A clock edge with `step_en` high advances the PC by one word when `br_taken` is low. An edge with `step_en` low leaves the PC unchanged. The PC wraps from all-ones to zero.
- R4: When `step_en` and `br_taken` are both high, the PC loads `br_target`. If `br_target` equals the current PC, the PC instead advances by one.
- R5: Byte-address bit 17 (parameter `SEL_BIT`) chooses the map. A value of 1 selects map 1 and a value of 0 selects map 0.
- R6: If bit 12 of the selected map is 1, `fetch_imem` is 1. Otherwise `fetch_imem` is 0 and `fetch_region` equals bits 7:0 of that map. The other map bits are ignored.
- R7: `fetch_fault` is 1 exactly when the fetch goes to a unified region whose bit in `REGION_PRESENT` is 0 (default populated regions: 0, 1, 2, 127). While the fault is present, `step_en` has no effect and the PC holds.
- R8: When repeat is active and the stepped PC equals the loop end, the count decrements. If the new count is nonzero, the PC loads the loop start.
- R9: When the decrement takes the count to zero, repeat becomes inactive and the PC stays at the loop end. A setup with count 0 leaves repeat inactive, so the PC runs straight past the end.
- R10: The loop-end comparison uses the PC after the branch or increment has been applied, so a branch that lands on the end address also counts as a pass.
- R11: A write on `map_wr_en` updates the map chosen by `map_wr_sel` (0 for map 0, 1 for map 1) at the clock edge. The new routing shows on the fetch outputs from that edge onward. `rpt_set` loads start, end and count at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_addr | input | 18 | Byte address loaded into the PC during reset |
| step_en | input | 1 | Retire one instruction at this edge |
| br_taken | input | 1 | The retiring instruction changed the PC |
| br_target | input | 16 | Word address the PC moves to on a taken branch |
| rpt_set | input | 1 | Load the repeat loop registers |
| rpt_start | input | 16 | Word address of the first instruction of the loop |
| rpt_end | input | 16 | Word address of the loop end |
| rpt_count | input | 16 | Number of passes through the loop |
| map_wr_en | input | 1 | Write a map register |
| map_wr_sel | input | 1 | Map to write: 0 or 1 |
| map_wr_data | input | 16 | New map value |
| fetch_addr | output | 18 | Byte fetch address |
| fetch_imem | output | 1 | 1: the fetch goes to the internal instruction store |
| fetch_region | output | 8 | Unified region number when `fetch_imem` is 0 |
| fetch_fault | output | 1 | The fetch targets an unpopulated region |

## Verification
All fetch outputs are combinational functions of registered state. A step, branch, repeat reload, map write or reset therefore appears on the outputs in the cycle right after the clock edge that captures it, and never earlier. The bench drives each stimulus for exactly one edge and samples 1 ns after that edge. For hold, ignore and fault cases it samples again after a further edge and checks that nothing has moved. Repeat behaviour is checked one step at a time, so each reload or loop exit is seen at the exact edge where it must take effect.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    localparam int MAP_W         = 16;
    localparam int IMEM_FLAG_BIT = 12;
    localparam int REGION_W      = 8;
    localparam logic [MAP_W-1:0] MAP_RESET = 16'h1000;
endpackage

// File: rtl/pcseq_fetch_map.sv
module pcseq_fetch_map
    import pcseq_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int SEL_BIT = 17,
    parameter logic [(2**REGION_W)-1:0] REGION_PRESENT = '0,
    localparam int BADDR_W = PC_W + 2
) (
    input  logic [PC_W-1:0]     pc,
    input  logic                m0_imem,
    input  logic [REGION_W-1:0] m0_region,
    input  logic                m1_imem,
    input  logic [REGION_W-1:0] m1_region,
    output logic [BADDR_W-1:0]  byte_addr,
    output logic                to_imem,
    output logic [REGION_W-1:0] region,
    output logic                fault
);
    always_comb begin
        byte_addr = {pc, 2'b00};
        if (byte_addr[SEL_BIT]) begin
            to_imem = m1_imem;
            region  = m1_region;
        end else begin
            to_imem = m0_imem;
            region  = m0_region;
        end
        fault = !to_imem && !REGION_PRESENT[region];
    end
endmodule

// File: rtl/pcseq_advance.sv
module pcseq_advance #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             go,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic             rpt_on,
    input  logic [PC_W-1:0]  rpt_start,
    input  logic [PC_W-1:0]  rpt_end,
    input  logic [CNT_W-1:0] rpt_cnt,
    output logic [PC_W-1:0]  pc_n,
    output logic [CNT_W-1:0] cnt_n,
    output logic             on_n
);
    logic [PC_W-1:0]  stepped;
    logic [CNT_W-1:0] cnt_dec;

    always_comb begin
        pc_n    = pc;
        cnt_n   = rpt_cnt;
        on_n    = rpt_on;
        cnt_dec = rpt_cnt - CNT_W'(1);
        if (br_taken && (br_target != pc)) stepped = br_target;
        else                               stepped = pc + PC_W'(1);
        if (go) begin
            pc_n = stepped;
            if (rpt_on && (stepped == rpt_end)) begin
                cnt_n = cnt_dec;
                if (cnt_dec == '0) on_n = 1'b0;
                else               pc_n = rpt_start;
            end
        end
    end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int CNT_W   = 16,
    parameter int SEL_BIT = 17,
    parameter logic [(2**REGION_W)-1:0] REGION_PRESENT =
        ((2**REGION_W)'(1) << 127) | (2**REGION_W)'(7),
    localparam int BADDR_W = PC_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BADDR_W-1:0]  start_addr,
    input  logic                step_en,
    input  logic                br_taken,
    input  logic [PC_W-1:0]     br_target,
    input  logic                rpt_set,
    input  logic [PC_W-1:0]     rpt_start,
    input  logic [PC_W-1:0]     rpt_end,
    input  logic [CNT_W-1:0]    rpt_count,
    input  logic                map_wr_en,
    input  logic                map_wr_sel,
    input  logic [MAP_W-1:0]    map_wr_data,
    output logic [BADDR_W-1:0]  fetch_addr,
    output logic                fetch_imem,
    output logic [REGION_W-1:0] fetch_region,
    output logic                fetch_fault
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [MAP_W-1:0] map0;
        logic [MAP_W-1:0] map1;
        logic [PC_W-1:0]  rs;
        logic [PC_W-1:0]  re;
        logic [CNT_W-1:0] rc;
        logic             ron;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [PC_W-1:0]  adv_pc;
    logic [CNT_W-1:0] adv_cnt;
    logic             adv_on;

    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  rpt_start_q;
    logic [PC_W-1:0]  rpt_end_q;
    logic [CNT_W-1:0] rpt_cnt_q;
    logic             rpt_active_q;

    assign pc_q         = s_q.pc;
    assign rpt_start_q  = s_q.rs;
    assign rpt_end_q    = s_q.re;
    assign rpt_cnt_q    = s_q.rc;
    assign rpt_active_q = s_q.ron;

    pcseq_fetch_map #(
        .PC_W(PC_W), .SEL_BIT(SEL_BIT), .REGION_PRESENT(REGION_PRESENT)
    ) u_map (
        .pc        (s_q.pc),
        .m0_imem   (s_q.map0[IMEM_FLAG_BIT]),
        .m0_region (s_q.map0[REGION_W-1:0]),
        .m1_imem   (s_q.map1[IMEM_FLAG_BIT]),
        .m1_region (s_q.map1[REGION_W-1:0]),
        .byte_addr (fetch_addr),
        .to_imem   (fetch_imem),
        .region    (fetch_region),
        .fault     (fetch_fault)
    );

    pcseq_advance #(.PC_W(PC_W), .CNT_W(CNT_W)) u_adv (
        .pc        (s_q.pc),
        .go        (step_en && !fetch_fault),
        .br_taken  (br_taken),
        .br_target (br_target),
        .rpt_on    (s_q.ron),
        .rpt_start (s_q.rs),
        .rpt_end   (s_q.re),
        .rpt_cnt   (s_q.rc),
        .pc_n      (adv_pc),
        .cnt_n     (adv_cnt),
        .on_n      (adv_on)
    );

    always_comb begin
        s_d     = s_q;
        s_d.pc  = adv_pc;
        s_d.rc  = adv_cnt;
        s_d.ron = adv_on;
        if (rpt_set) begin
            s_d.rs  = rpt_start;
            s_d.re  = rpt_end;
            s_d.rc  = rpt_count;
            s_d.ron = (rpt_count != '0);
        end
        if (map_wr_en) begin
            if (map_wr_sel) s_d.map1 = map_wr_data;
            else            s_d.map0 = map_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.pc   <= PC_W'(start_addr >> 2);
            s_q.map0 <= MAP_RESET;
            s_q.map1 <= MAP_RESET;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16,
    localparam int BADDR_W = PC_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_en,
    input logic               br_taken,
    input logic               rpt_set,
    input logic               fetch_fault,
    input logic               fetch_imem,
    input logic [BADDR_W-1:0] fetch_addr,
    input logic [PC_W-1:0]    pc_q,
    input logic [PC_W-1:0]    rpt_start_q,
    input logic [PC_W-1:0]    rpt_end_q,
    input logic [CNT_W-1:0]   rpt_cnt_q,
    input logic               rpt_active_q
);
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(fetch_addr)); // R3
    AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !fetch_fault && !br_taken && !rpt_active_q)
        |=> (pc_q == $past(pc_q) + PC_W'(1))); // R3
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fault |=> $stable(pc_q)); // R7
    AST_FAULT_UNIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fault |-> !fetch_imem); // R7
    AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !fetch_fault && !br_taken && rpt_active_q &&
         (pc_q + PC_W'(1) == rpt_end_q) && (rpt_cnt_q > CNT_W'(1)))
        |=> (pc_q == $past(rpt_start_q))); // R8
    AST_CNT_DECR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rpt_set && rpt_active_q)
        |=> ((rpt_cnt_q == $past(rpt_cnt_q)) ||
             (rpt_cnt_q == $past(rpt_cnt_q) - CNT_W'(1)))); // R9
endmodule

bind pcseq_top pcseq_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (step_en),
    .br_taken     (br_taken),
    .rpt_set      (rpt_set),
    .fetch_fault  (fetch_fault),
    .fetch_imem   (fetch_imem),
    .fetch_addr   (fetch_addr),
    .pc_q         (pc_q),
    .rpt_start_q  (rpt_start_q),
    .rpt_end_q    (rpt_end_q),
    .rpt_cnt_q    (rpt_cnt_q),
    .rpt_active_q (rpt_active_q)
);

// File: tb/tb_pcseq_top.sv
`timescale 1ns/1ps
module tb_pcseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] start_addr = 18'h00100;
    logic        step_en = 1'b0, br_taken = 1'b0;
    logic [15:0] br_target = '0;
    logic        rpt_set = 1'b0;
    logic [15:0] rpt_start = '0, rpt_end = '0, rpt_count = '0;
    logic        map_wr_en = 1'b0, map_wr_sel = 1'b0;
    logic [15:0] map_wr_data = '0;
    logic [17:0] fetch_addr;
    logic        fetch_imem;
    logic [7:0]  fetch_region;
    logic        fetch_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcseq_top dut (.*);

    // {step, br, target[15:0], expected fetch_addr[17:0]}
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 1'b0, 16'h0000, 18'h00104},
        {1'b0, 1'b1, 16'h0200, 18'h00104},
        {1'b1, 1'b1, 16'h0200, 18'h00800},
        {1'b1, 1'b1, 16'h0200, 18'h00804},
        {1'b1, 1'b0, 16'h0000, 18'h00808},
        {1'b1, 1'b1, 16'h8000, 18'h20000},
        {1'b1, 1'b1, 16'hFFFF, 18'h3FFFC},
        {1'b1, 1'b0, 16'h0000, 18'h00000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic br, input logic [15:0] tgt);
        step_en = st; br_taken = br; br_target = tgt;
        @(posedge clk); #1;
        step_en = 1'b0; br_taken = 1'b0; rpt_set = 1'b0; map_wr_en = 1'b0;
    endtask

    task automatic wr_map(input logic sel, input logic [15:0] val);
        map_wr_en = 1'b1; map_wr_sel = sel; map_wr_data = val;
        cyc(1'b0, 1'b0, 16'h0);
    endtask

    task automatic setup_rpt(input logic [15:0] s, input logic [15:0] e, input logic [15:0] c);
        rpt_set = 1'b1; rpt_start = s; rpt_end = e; rpt_count = c;
        cyc(1'b0, 1'b0, 16'h0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2 reset state
        check("R2 addr", 32'(fetch_addr), 32'h100);
        check("R2 imem", 32'(fetch_imem), 32'h1);
        check("R2 fault", 32'(fetch_fault), 32'h0);

        // R1 R3 R4 table walk
        for (int i = 0; i < 8; i++) begin
            cyc(VEC[i][35], VEC[i][34], VEC[i][33:18]);
            check("R1/R3/R4 vector", 32'(fetch_addr), 32'(VEC[i][17:0]));
            check("R6 imem via table", 32'(fetch_imem), 32'h1);
        end

        // R11 R5 R6: map1 -> region 1
        wr_map(1'b1, 16'h0001);
        check("R5 map0 still used", 32'(fetch_imem), 32'h1);
        cyc(1'b1, 1'b1, 16'h8000);
        check("R5 map1 selected", 32'(fetch_imem), 32'h0);
        check("R6 region", 32'(fetch_region), 32'h1);
        check("R7 present no fault", 32'(fetch_fault), 32'h0);
        // R7 absent region
        wr_map(1'b1, 16'h0005);
        check("R11 R7 fault after write", 32'(fetch_fault), 32'h1);
        cyc(1'b1, 1'b1, 16'h0010);
        check("R7 step ignored", 32'(fetch_addr), 32'h20000);
        cyc(1'b1, 1'b0, 16'h0000);
        check("R7 step ignored again", 32'(fetch_addr), 32'h20000);
        wr_map(1'b1, 16'h1000);
        check("R7 fault cleared", 32'(fetch_fault), 32'h0);
        check("R6 imem flag", 32'(fetch_imem), 32'h1);
        // R5: map0 write does not affect map1-selected fetch
        wr_map(1'b0, 16'h0102);
        check("R5 map1 unaffected", 32'(fetch_imem), 32'h1);
        cyc(1'b1, 1'b1, 16'h0010);
        check("R4 branch", 32'(fetch_addr), 32'h40);
        check("R6 region low bits", 32'(fetch_region), 32'h2);
        check("R6 unified", 32'(fetch_imem), 32'h0);
        wr_map(1'b0, 16'h1000);

        // R8 R9 repeat loop 0x11..0x13 twice
        setup_rpt(16'h0011, 16'h0013, 16'h0002);
        check("R11 rpt_set no pc move", 32'(fetch_addr), 32'h40);
        cyc(1'b1, 1'b0, 16'h0); check("R8 pass1 a", 32'(fetch_addr), 32'h44);
        cyc(1'b1, 1'b0, 16'h0); check("R8 pass1 b", 32'(fetch_addr), 32'h48);
        cyc(1'b1, 1'b0, 16'h0); check("R8 reload start", 32'(fetch_addr), 32'h44);
        cyc(1'b1, 1'b0, 16'h0); check("R8 pass2 b", 32'(fetch_addr), 32'h48);
        cyc(1'b1, 1'b0, 16'h0); check("R9 exit at end", 32'(fetch_addr), 32'h4C);
        cyc(1'b1, 1'b0, 16'h0); check("R9 past end", 32'(fetch_addr), 32'h50);

        // R10 branch landing on end
        setup_rpt(16'h0020, 16'h0030, 16'h0001);
        cyc(1'b1, 1'b1, 16'h0030); check("R10 branch to end", 32'(fetch_addr), 32'hC0);
        cyc(1'b1, 1'b0, 16'h0);    check("R10 R9 loop done", 32'(fetch_addr), 32'hC4);

        // R9 count zero never active
        setup_rpt(16'h0040, 16'h0032, 16'h0000);
        cyc(1'b1, 1'b0, 16'h0); check("R9 zero count at end", 32'(fetch_addr), 32'hC8);
        cyc(1'b1, 1'b0, 16'h0); check("R9 zero count past", 32'(fetch_addr), 32'hCC);

        // R2 reset mid-run restores maps and loads PC
        wr_map(1'b1, 16'h0007);
        start_addr = 18'h20013;
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 16'h0);
        rst_n = 1'b1;
        check("R2 reload pc", 32'(fetch_addr), 32'h20010);
        check("R2 map1 reset", 32'(fetch_imem), 32'h1);
        check("R2 no fault", 32'(fetch_fault), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule